// File: doc/BRIEF.md
# Three-Bank Interrupt Controller Register Interface

This block is the word-addressed register interface of a level-sensitive interrupt controller with three banks of 32 lines each. It accepts one 32-bit access at a time over a request/response register bus. It decodes each access to a global register, a per-bank register, or a per-line level register. It keeps the per-bank mask, software-interrupt and pending vectors, and the per-line priority and fast-path select fields. It drives these fields and a set of single-cycle strobes to an arbiter outside the block. It reads back the winning IRQ and FIQ codes that the arbiter returns.

Each bank keeps its pending vector up to date from the raw line levels. A line that rises sets its pending bit. A line that falls reloads the whole pending vector from the current levels ORed with the software vector. The mask and the software vector each have separate set and clear aliases, so that software can change single bits without a read-modify-write. Two pending views split the unmasked pending lines into those routed to the normal path and those routed to the fast path.

A small state machine sequences every access. ST_IDLE accepts a request (T_ACCEPT). From there it moves to ST_RESP for an ordinary access (T_TO_RESP), or to ST_SRST for a soft-reset write (T_TO_SRST). ST_SRST returns every register to its reset value for one cycle and then moves to ST_RESP (T_SRST_DONE). ST_RESP presents the response for one cycle and returns to ST_IDLE (T_RESP_DONE).

Top module: `intc_regfile`

## Requirements
- R1: `req_ready` is high only in ST_IDLE. Each accepted request gets exactly one `rsp_valid` cycle: one cycle after acceptance for an ordinary access, two cycles after acceptance for a soft-reset write.
- R2: Offset 0x000 reads the revision 0x21, and offset 0x014 always reads 1 (reset done). Writes to either offset change nothing.
- R3: Offset 0x040 reads `irq_code_i` and offset 0x044 reads `fiq_code_i`, both zero-extended.
- R4: At offset 0x048, bit 2 is the global mask, which can be read and written; a read returns only bit 2. A write with bit 0 set pulses `new_irq_agr_o`, and a write with bit 1 set pulses `new_fiq_agr_o`. The pulse lasts one cycle and coincides with the response.
- R5: At offset 0x010, bit 0 is auto-idle and can be read and written. Offset 0x050 holds two idle bits in [1:0]. All other bits of both registers read 0.
- R6: A write to 0x010 with bit 1 set resets all state: masks to all ones; software, pending, fast-path select, priorities, global mask, auto-idle and idle bits to 0.
- R7: Bank b (b = 0..2) has its registers at 0x080 + 0x20*b. The register at +0x00 reads the sampled raw line levels, and the register at +0x04 holds the mask, which can be read and written. Bank index 3 (0x0E0) is undecoded.
- R8: A write to +0x08 clears mask bits and a write to +0x0C sets mask bits; both read 0. A full mask write or a mask-clear write pulses `refresh_o`; a mask-set write does not.
- R9: A write to +0x10 ORs the data into both the software vector and the pending vector, and pulses `refresh_o`. A read of +0x10 returns the software vector.
- R10: A write to +0x14 removes the data bits from the software vector and then loads pending with (software AND sampled raw levels). A read of +0x14 returns 0.
- R11: +0x18 reads pending AND NOT mask AND NOT fast-select. +0x1C reads pending AND NOT mask AND fast-select.
- R12: A rising raw line sets its pending bit. Any falling raw line in a bank reloads that bank's pending vector with (raw levels OR software vector).
- R13: The line register of line n of bank b sits at 0x100 + 0x80*b + 4*n. Bits [7:2] hold the priority and bit 0 holds the fast-path select; all other bits read 0 and are not stored.
- R14: An access with `req_be` other than 4'hF, a misaligned address, or an undecoded offset is ignored on write and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address |
| req_be | input | 4 | Byte enables; only 4'hF is honoured |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response cycle |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| line_level_i | input | 96 | Raw interrupt line levels |
| irq_code_i | input | 7 | Winning normal-path line from the arbiter |
| fiq_code_i | input | 7 | Winning fast-path line from the arbiter |
| mask_o | output | 96 | Per-line mask (1 = masked) |
| fiq_sel_o | output | 96 | Per-line fast-path select |
| prio_o | output | 576 | Per-line 6-bit priority, line n at [6n +: 6] |
| pend_o | output | 96 | Pending vector |
| glob_mask_o | output | 1 | Global mask |
| autoidle_o | output | 1 | Auto-idle bit |
| idle_o | output | 2 | Idle bits |
| refresh_o | output | 1 | Re-evaluation strobe |
| new_irq_agr_o | output | 1 | Normal-path new-agreement strobe |
| new_fiq_agr_o | output | 1 | Fast-path new-agreement strobe |

## Verification
The bench sweeps every line register with distinct priority values and junk in the unused bits. A decoder that put the bank or the line in the wrong place would alias entries and return the wrong value; one that stored the unused bits would read them back. It runs the aliases against known masks: a set/clear mix-up, or a mask-set that pulsed the refresh strobe, shows up as a wrong mask or a wrong strobe. It drives line rises and falls with and without software bits. A design that treated a fall as a single-bit clear would leave stale pending bits that a later view read exposes. It checks that soft reset takes one extra response cycle and clears every field, and that partial, misaligned and out-of-range accesses leave the state untouched.

// File: rtl/intc_rf_pkg.sv
package intc_rf_pkg;
    localparam int unsigned DW     = 32;
    localparam int unsigned AW     = 12;
    localparam int unsigned LPB    = 32;   // lines per bank
    localparam int unsigned BANK_W = 2;    // bank field width in the map
    localparam int unsigned LINE_W = 5;

    typedef enum logic [1:0] {ST_IDLE, ST_RESP, ST_SRST} fsm_e;

    typedef enum logic [3:0] {
        K_NONE, K_REV, K_SYSCFG, K_SYSSTAT, K_IRQCODE,
        K_FIQCODE, K_CTRL, K_IDLE, K_BANK, K_LINE
    } kind_e;

    // order follows the per-bank offset map (+0x00 .. +0x1C)
    typedef enum logic [2:0] {
        SB_RAW, SB_MASK, SB_MCLR, SB_MSET,
        SB_SSET, SB_SCLR, SB_PIRQ, SB_PFIQ
    } sub_e;

    typedef struct packed {
        kind_e              kind;
        logic [BANK_W-1:0]  bank;
        sub_e               sub;
        logic [LINE_W-1:0]  line;
    } dec_t;
endpackage

// File: rtl/intc_rf_decode.sv
module intc_rf_decode
    import intc_rf_pkg::*;
#(
    parameter int NUM_BANKS = 3
) (
    input  logic [AW-1:0] addr,
    input  logic [3:0]    be,
    output dec_t          dec
);
    localparam int LINE_BASE = 256;
    localparam int LINE_END  = LINE_BASE + 128 * NUM_BANKS;

    logic [AW-1:0] loff;
    assign loff = addr - 12'h100;

    always_comb begin
        dec = '{kind: K_NONE, bank: '0, sub: SB_RAW, line: '0};
        if (be == 4'hF && addr[1:0] == 2'b00) begin
            if (addr[11:7] == 5'd1) begin
                if (int'(addr[6:5]) < NUM_BANKS) begin
                    dec.kind = K_BANK;
                    dec.bank = addr[6:5];
                    dec.sub  = sub_e'(addr[4:2]);
                end
            end else if (int'(addr) >= LINE_BASE && int'(addr) < LINE_END) begin
                dec.kind = K_LINE;
                dec.bank = loff[8:7];
                dec.line = loff[6:2];
            end else begin
                unique case (addr)
                    12'h000: dec.kind = K_REV;
                    12'h010: dec.kind = K_SYSCFG;
                    12'h014: dec.kind = K_SYSSTAT;
                    12'h040: dec.kind = K_IRQCODE;
                    12'h044: dec.kind = K_FIQCODE;
                    12'h048: dec.kind = K_CTRL;
                    12'h050: dec.kind = K_IDLE;
                    default: dec.kind = K_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/intc_rf_bank.sv
module intc_rf_bank
    import intc_rf_pkg::*;
#(
    parameter int PRIO_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  srst,
    input  logic [LPB-1:0]        raw_i,
    input  logic                  bank_we,
    input  sub_e                  wr_sub,
    input  logic                  line_we,
    input  logic [LINE_W-1:0]     wr_line,
    input  logic [DW-1:0]         wdata,
    input  sub_e                  rd_sub,
    input  logic [LINE_W-1:0]     rd_line,
    output logic [DW-1:0]         rd_bank,
    output logic [DW-1:0]         rd_lin,
    output logic [LPB-1:0]        mask_o,
    output logic [LPB-1:0]        fiq_o,
    output logic [LPB-1:0]        pend_o,
    output logic [LPB*PRIO_W-1:0] prio_o
);
    logic [LPB-1:0]    raw_q, mask_q, sw_q, pend_q, fiq_q;
    logic [PRIO_W-1:0] prio_q [LPB];
    logic [LPB-1:0]    rise, fall, pend_evt, mask_n, sw_n, pend_n;

    // level capture: rise sets a bit, any fall reloads from levels and software
    always_comb begin
        rise     = raw_i & ~raw_q;
        fall     = raw_q & ~raw_i;
        pend_evt = (|fall) ? (raw_i | sw_q) : (pend_q | rise);
        mask_n   = mask_q;
        sw_n     = sw_q;
        pend_n   = pend_evt;
        if (bank_we) begin
            case (wr_sub)
                SB_MASK: mask_n = wdata;
                SB_MCLR: mask_n = mask_q & ~wdata;
                SB_MSET: mask_n = mask_q | wdata;
                SB_SSET: begin
                    sw_n   = sw_q | wdata;
                    pend_n = pend_evt | sw_n;
                end
                SB_SCLR: begin
                    sw_n   = sw_q & ~wdata;
                    pend_n = sw_n & raw_q;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q  <= '0;
            mask_q <= '1;
            sw_q   <= '0;
            pend_q <= '0;
            fiq_q  <= '0;
            for (int i = 0; i < LPB; i++) prio_q[i] <= '0;
        end else if (srst) begin
            raw_q  <= '0;
            mask_q <= '1;
            sw_q   <= '0;
            pend_q <= '0;
            fiq_q  <= '0;
            for (int i = 0; i < LPB; i++) prio_q[i] <= '0;
        end else begin
            raw_q  <= raw_i;
            mask_q <= mask_n;
            sw_q   <= sw_n;
            pend_q <= pend_n;
            if (line_we) begin
                prio_q[wr_line] <= wdata[2 +: PRIO_W];
                fiq_q[wr_line]  <= wdata[0];
            end
        end
    end

    always_comb begin
        rd_bank = '0;
        case (rd_sub)
            SB_RAW:  rd_bank = raw_q;
            SB_MASK: rd_bank = mask_q;
            SB_SSET: rd_bank = sw_q;
            SB_PIRQ: rd_bank = pend_q & ~mask_q & ~fiq_q;
            SB_PFIQ: rd_bank = pend_q & ~mask_q & fiq_q;
            default: rd_bank = '0;
        endcase
        rd_lin = '0;
        rd_lin[2 +: PRIO_W] = prio_q[rd_line];
        rd_lin[0] = fiq_q[rd_line];
    end

    assign mask_o = mask_q;
    assign fiq_o  = fiq_q;
    assign pend_o = pend_q;
    for (genvar g = 0; g < LPB; g++) begin : g_prio
        assign prio_o[g*PRIO_W +: PRIO_W] = prio_q[g];
    end

    a_r8_mclr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_we && wr_sub == SB_MCLR) |=> ((mask_q & $past(wdata)) == '0));
    a_r9_sset_pends: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_we && wr_sub == SB_SSET) |=> ((pend_q & $past(wdata)) == $past(wdata)));
    a_r10_sclr_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_we && wr_sub == SB_SCLR) |=> ((sw_q & $past(wdata)) == '0));
    a_r6_srst_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (mask_q == '1 && sw_q == '0 && fiq_q == '0));
endmodule

// File: rtl/intc_regfile.sv
module intc_regfile
    import intc_rf_pkg::*;
#(
    parameter int         NUM_BANKS = 3,
    parameter int         PRIO_W    = 6,
    parameter logic [7:0] REVISION  = 8'h21,
    localparam int        LINES     = NUM_BANKS * LPB,
    localparam int        CODE_W    = $clog2(LINES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_write,
    input  logic [AW-1:0]           req_addr,
    input  logic [3:0]              req_be,
    input  logic [DW-1:0]           req_wdata,
    output logic                    rsp_valid,
    output logic [DW-1:0]           rsp_rdata,
    input  logic [LINES-1:0]        line_level_i,
    input  logic [CODE_W-1:0]       irq_code_i,
    input  logic [CODE_W-1:0]       fiq_code_i,
    output logic [LINES-1:0]        mask_o,
    output logic [LINES-1:0]        fiq_sel_o,
    output logic [LINES*PRIO_W-1:0] prio_o,
    output logic [LINES-1:0]        pend_o,
    output logic                    glob_mask_o,
    output logic                    autoidle_o,
    output logic [1:0]              idle_o,
    output logic                    refresh_o,
    output logic                    new_irq_agr_o,
    output logic                    new_fiq_agr_o
);
    fsm_e          state_q, state_n;
    dec_t          dec;
    logic          accept, wr_acc, srst_wr, srst;
    logic          glob_q, autoidle_q;
    logic [1:0]    idle_q;
    logic [DW-1:0] rd_n, bank_sel, line_sel;
    logic [DW-1:0] bank_rd [NUM_BANKS];
    logic [DW-1:0] line_rd [NUM_BANKS];

    intc_rf_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
        .addr (req_addr),
        .be   (req_be),
        .dec  (dec)
    );

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign wr_acc    = accept && req_write;
    assign srst_wr   = wr_acc && dec.kind == K_SYSCFG && req_wdata[1];
    assign srst      = (state_q == ST_SRST);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        intc_rf_bank #(.PRIO_W(PRIO_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .srst    (srst),
            .raw_i   (line_level_i[b*LPB +: LPB]),
            .bank_we (wr_acc && dec.kind == K_BANK && int'(dec.bank) == b),
            .wr_sub  (dec.sub),
            .line_we (wr_acc && dec.kind == K_LINE && int'(dec.bank) == b),
            .wr_line (dec.line),
            .wdata   (req_wdata),
            .rd_sub  (dec.sub),
            .rd_line (dec.line),
            .rd_bank (bank_rd[b]),
            .rd_lin  (line_rd[b]),
            .mask_o  (mask_o[b*LPB +: LPB]),
            .fiq_o   (fiq_sel_o[b*LPB +: LPB]),
            .pend_o  (pend_o[b*LPB +: LPB]),
            .prio_o  (prio_o[b*LPB*PRIO_W +: LPB*PRIO_W])
        );
    end

    // read data mux
    always_comb begin
        bank_sel = '0;
        line_sel = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (int'(dec.bank) == b) begin
                bank_sel = bank_rd[b];
                line_sel = line_rd[b];
            end
        end
        rd_n = '0;
        if (!req_write) begin
            case (dec.kind)
                K_REV:     rd_n = DW'(REVISION);
                K_SYSCFG:  rd_n = DW'(autoidle_q);
                K_SYSSTAT: rd_n = DW'(1);
                K_IRQCODE: rd_n = DW'(irq_code_i);
                K_FIQCODE: rd_n = DW'(fiq_code_i);
                K_CTRL:    rd_n = DW'({glob_q, 2'b00});
                K_IDLE:    rd_n = DW'(idle_q);
                K_BANK:    rd_n = bank_sel;
                K_LINE:    rd_n = line_sel;
                default:   rd_n = '0;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // transitions
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_n = srst_wr ? ST_SRST : ST_RESP; // T_TO_SRST / T_TO_RESP
            ST_SRST: state_n = ST_RESP;                                 // T_SRST_DONE
            ST_RESP: state_n = ST_IDLE;                                 // T_RESP_DONE
            default: state_n = ST_IDLE;
        endcase
    end

    // outputs and global registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_rdata     <= '0;
            glob_q        <= 1'b0;
            autoidle_q    <= 1'b0;
            idle_q        <= '0;
            refresh_o     <= 1'b0;
            new_irq_agr_o <= 1'b0;
            new_fiq_agr_o <= 1'b0;
        end else begin
            rsp_valid     <= (state_n == ST_RESP);
            refresh_o     <= 1'b0;
            new_irq_agr_o <= 1'b0;
            new_fiq_agr_o <= 1'b0;
            if (accept) rsp_rdata <= rd_n;
            if (srst) begin
                glob_q     <= 1'b0;
                autoidle_q <= 1'b0;
                idle_q     <= '0;
            end else if (wr_acc) begin
                case (dec.kind)
                    K_SYSCFG: autoidle_q <= req_wdata[0];
                    K_IDLE:   idle_q     <= req_wdata[1:0];
                    K_CTRL: begin
                        glob_q        <= req_wdata[2];
                        new_fiq_agr_o <= req_wdata[1];
                        new_irq_agr_o <= req_wdata[0];
                    end
                    K_BANK: refresh_o <= (dec.sub == SB_MASK) || (dec.sub == SB_MCLR)
                                         || (dec.sub == SB_SSET);
                    default: ;
                endcase
            end
        end
    end

    assign glob_mask_o = glob_q;
    assign autoidle_o  = autoidle_q;
    assign idle_o      = idle_q;

    a_r1_one_beat: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    a_r1_busy_in_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
    a_r4_agr_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (new_irq_agr_o || new_fiq_agr_o) |-> rsp_valid);
    a_r8_refresh_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_o |-> rsp_valid);
endmodule

// File: tb/intc_regfile_bench.sv
module intc_regfile_bench;
    localparam int LINES = 96;
    localparam int PW    = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0, req_write = 1'b0;
    logic [11:0]       req_addr = '0;
    logic [3:0]        req_be = '0;
    logic [31:0]       req_wdata = '0;
    logic              req_ready, rsp_valid;
    logic [31:0]       rsp_rdata;
    logic [LINES-1:0]  lines = '0;
    logic [6:0]        irq_code = '0, fiq_code = '0;
    logic [LINES-1:0]  mask_o, fiq_sel_o, pend_o;
    logic [LINES*PW-1:0] prio_o;
    logic              glob_mask_o, autoidle_o, refresh_o, new_irq_agr_o, new_fiq_agr_o;
    logic [1:0]        idle_o;

    int nchk = 0, nerr = 0;
    bit done = 0;
    logic p_irq, p_fiq, p_ref;
    int lat;
    logic [31:0] q;

    always #2.5 clk = ~clk;

    intc_regfile u_intc_regfile (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .line_level_i(lines), .irq_code_i(irq_code), .fiq_code_i(fiq_code),
        .mask_o(mask_o), .fiq_sel_o(fiq_sel_o), .prio_o(prio_o), .pend_o(pend_o),
        .glob_mask_o(glob_mask_o), .autoidle_o(autoidle_o), .idle_o(idle_o),
        .refresh_o(refresh_o), .new_irq_agr_o(new_irq_agr_o),
        .new_fiq_agr_o(new_fiq_agr_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus(input logic wr, input logic [11:0] a, input logic [3:0] be,
                       input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid) begin
            @(negedge clk);
            lat++;
        end
        q = rsp_rdata; p_irq = new_irq_agr_o; p_fiq = new_fiq_agr_o; p_ref = refresh_o;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus(1'b1, a, 4'hF, d);
    endtask

    task automatic rd(input logic [11:0] a);
        bus(1'b0, a, 4'hF, 32'h0);
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 / R6 reset state
        chk("R1 ready after reset", 32'(req_ready), 32'd1);
        chk("R6 mask_o reset", 32'(&mask_o), 32'd1);
        rd(12'h084); chk("R7 bank0 mask reset", q, 32'hFFFF_FFFF);
        chk("R1 read latency", lat, 1);

        // R2
        rd(12'h000); chk("R2 revision", q, 32'h21);
        wr(12'h000, 32'h0); rd(12'h000); chk("R2 revision after write", q, 32'h21);
        rd(12'h014); chk("R2 reset done", q, 32'h1);

        // R3
        irq_code = 7'h55; fiq_code = 7'h12;
        rd(12'h040); chk("R3 irq code", q, 32'h55);
        rd(12'h044); chk("R3 fiq code", q, 32'h12);

        // R4
        wr(12'h048, 32'h7);
        chk("R4 irq agr pulse", 32'(p_irq), 32'd1);
        chk("R4 fiq agr pulse", 32'(p_fiq), 32'd1);
        chk("R4 glob port", 32'(glob_mask_o), 32'd1);
        rd(12'h048); chk("R4 ctrl read", q, 32'h4);
        wr(12'h048, 32'h0); chk("R4 no pulse", 32'({p_irq, p_fiq}), 32'd0);
        rd(12'h048); chk("R4 glob clear", q, 32'h0);
        wr(12'h048, 32'h4);

        // R5
        wr(12'h010, 32'h1); rd(12'h010); chk("R5 autoidle", q, 32'h1);
        wr(12'h050, 32'hFFFF_FFFF); rd(12'h050); chk("R5 idle bits", q, 32'h3);
        chk("R5 idle port", 32'(idle_o), 32'h3);

        // R7 bank sweep
        for (int b = 0; b < 3; b++) begin
            logic [31:0] pat;
            pat = 32'hA5C3_0000 ^ (32'(b + 1) * 32'h0101_0101);
            wr(12'(12'h084 + 32 * b), pat);
            rd(12'(12'h084 + 32 * b)); chk("R7 mask readback", q, pat);
            lines[b*32 +: 32] = ~pat;
            settle();
            rd(12'(12'h080 + 32 * b)); chk("R7 raw levels", q, ~pat);
            lines[b*32 +: 32] = '0;
            settle();
        end
        wr(12'h0E4, 32'h0); rd(12'h0E4); chk("R7 bank3 undecoded", q, 32'h0);

        // R8
        wr(12'h084, 32'hFFFF_FFFF); chk("R8 mask write refresh", 32'(p_ref), 32'd1);
        wr(12'h088, 32'h0000_F0F0); chk("R8 mclr refresh", 32'(p_ref), 32'd1);
        rd(12'h084); chk("R8 mask after clear", q, 32'hFFFF_0F0F);
        rd(12'h088); chk("R8 mclr reads 0", q, 32'h0);
        wr(12'h08C, 32'h0000_00F0); chk("R8 mset no refresh", 32'(p_ref), 32'd0);
        rd(12'h084); chk("R8 mask after set", q, 32'hFFFF_0FFF);
        rd(12'h08C); chk("R8 mset reads 0", q, 32'h0);

        // R13 line sweep
        for (int i = 0; i < LINES; i++) begin
            int pr, fq;
            pr = (i * 7 + 3) % 64; fq = i % 2;
            wr(12'(256 + 4 * i), 32'hFFFF_FF00 | 32'(pr << 2) | 32'h2 | 32'(fq));
        end
        for (int i = 0; i < LINES; i++) begin
            int pr, fq;
            pr = (i * 7 + 3) % 64; fq = i % 2;
            rd(12'(256 + 4 * i));
            chk("R13 line readback", q, 32'(pr << 2) | 32'(fq));
        end
        chk("R13 prio port line 40", 32'(prio_o[40*PW +: PW]), 32'((40 * 7 + 3) % 64));
        chk("R13 fiq port line 41", 32'(fiq_sel_o[41]), 32'd1);

        // R9 / R11 / R10 on bank 1
        wr(12'h0A4, 32'h0);
        wr(12'h0B0, 32'h11); chk("R9 sset refresh", 32'(p_ref), 32'd1);
        rd(12'h0B0); chk("R9 sw readback", q, 32'h11);
        rd(12'h0B8); chk("R9 pending irq view", q, 32'h11);
        rd(12'h0BC); chk("R11 pending fiq view empty", q, 32'h0);
        wr(12'h180, 32'h1);
        rd(12'h0B8); chk("R11 irq view after select", q, 32'h10);
        rd(12'h0BC); chk("R11 fiq view after select", q, 32'h01);
        lines[32] = 1'b1; settle();
        wr(12'h0B4, 32'h10);
        rd(12'h0B4); chk("R10 sclr reads 0", q, 32'h0);
        rd(12'h0B0); chk("R10 sw after clear", q, 32'h1);
        rd(12'h0B8); chk("R10 irq view", q, 32'h0);
        rd(12'h0BC); chk("R10 fiq view", q, 32'h1);
        wr(12'h0AC, 32'h1);
        rd(12'h0BC); chk("R11 masked fiq view", q, 32'h0);
        lines[32] = 1'b0; settle();

        // R12 on bank 2
        wr(12'h0C4, 32'h0);
        lines[68] = 1'b1; lines[69] = 1'b1; settle();
        rd(12'h0D8); chk("R12 rise irq view", q, 32'h10);
        rd(12'h0DC); chk("R12 rise fiq view", q, 32'h20);
        lines[69] = 1'b0; settle();
        rd(12'h0DC); chk("R12 fall reload fiq", q, 32'h0);
        rd(12'h0D8); chk("R12 fall keeps level", q, 32'h10);
        wr(12'h0D0, 32'h100);
        lines[68] = 1'b0; settle();
        rd(12'h0D8); chk("R12 fall reload sw", q, 32'h100);
        chk("R12 pend port", pend_o[64 +: 32], 32'h100);

        // R14
        bus(1'b1, 12'h084, 4'h3, 32'h0);
        rd(12'h084); chk("R14 partial write ignored", q, 32'hFFFF_0FFF);
        bus(1'b0, 12'h084, 4'h7, 32'h0); chk("R14 partial read 0", q, 32'h0);
        wr(12'h086, 32'h0);
        rd(12'h084); chk("R14 misaligned ignored", q, 32'hFFFF_0FFF);
        rd(12'h04C); chk("R14 undecoded read", q, 32'h0);
        rd(12'h400); chk("R14 high undecoded", q, 32'h0);

        // R6 soft reset
        wr(12'h010, 32'h2); chk("R1 soft reset latency", lat, 2);
        rd(12'h084); chk("R6 bank0 mask", q, 32'hFFFF_FFFF);
        rd(12'h0A4); chk("R6 bank1 mask", q, 32'hFFFF_FFFF);
        rd(12'h0D0); chk("R6 sw cleared", q, 32'h0);
        rd(12'h1A8); chk("R6 line cleared", q, 32'h0);
        rd(12'h048); chk("R6 glob cleared", q, 32'h0);
        rd(12'h050); chk("R6 idle cleared", q, 32'h0);
        rd(12'h010); chk("R6 autoidle cleared", q, 32'h0);
        chk("R6 prio port", 32'(|prio_o), 32'd0);
        chk("R6 pend port", 32'(|pend_o), 32'd0);

        finish_run();
    end
endmodule